// File: doc/BRIEF.md
# Segment Register With Descriptor Cache

This block holds one segment register of a segmented memory model. Software sees a 16-bit selector. Behind it sits a cache that software cannot see, holding a linear base, a byte limit and the descriptor's attribute bits. When a new selector is written, the block splits it into an entry number, a table choice and a requested privilege level. It then reads the 8-byte descriptor from the global or the local table over a simple request/acknowledge memory read port. From the two little-endian words it receives, it rebuilds the base and the limit.

After that, any offset presented on the translation port is checked against the cached limit and turned into a linear address by adding the cached base. Translation uses only the cache. A descriptor fetch in progress stalls translation. A selector that names entry 0 of the global table marks the cache as null, and every translation through a null cache faults.

Top module: `seg_shadow_unit`

## Requirements
- R1: The selector is split as follows: bits 15:3 are the table entry number, bit 2 picks the table and bits 1:0 are the requested privilege level. The level appears on `sel_rpl`, and the accepted selector appears on `sel_q` in the cycle after the write.
- R2: When bit 2 is 0 the descriptor comes from `gdt_base`; when it is 1 it comes from `ldt_base`. The first word is read at the table base plus 8 times the entry number, and the second word 4 bytes above that.
- R3: A selector write accepted while idle, and not null, raises `busy` in the next cycle. `busy` stays high until the second word is acknowledged. `mem_rd_req` and `mem_rd_addr` stay stable until `mem_rd_ack` is seen.
- R4: The cache is refilled from the two words w0 and w1. The base is {w1[31:24], w1[7:0], w0[31:16]}. The raw limit is {w1[19:16], w0[15:0]}. The granularity flag is w1[23]; when it is set, the limit is the raw limit shifted left by 12 with twelve one bits filled in below. `seg_attr` is {w1[23:20], w1[15:8]}.
- R5: A translation request made while not busy gives, one cycle later, `xl_valid`=1. When the offset is not above the limit, it also gives `xl_fault`=0 and `xl_lin` = base + offset, modulo 2^32.
- R6: An offset above the cached limit gives `xl_valid`=1, `xl_fault`=1 and `xl_lin`=0.
- R7: A translation request made while `busy` is high is not accepted: `xl_valid` is 0 in the following cycle.
- R8: After reset `sel_q` is 0 and `busy` is 0. The cache holds base 0, limit 0xFFFFFFFF and is not null, so every offset translates to itself without fault.
- R9: A selector whose bits 15:2 are all zero starts no memory read and leaves `busy` low. Every later translation faults until a non-null selector is loaded.
- R10: A selector write while `busy` is high is ignored: `sel_q` keeps its value and no extra descriptor read is made.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sel_wr | input | 1 | Selector write strobe |
| sel_wdata | input | 16 | New selector value |
| gdt_base | input | 32 | Linear base of the global descriptor table |
| ldt_base | input | 32 | Linear base of the local descriptor table |
| mem_rd_req | output | 1 | Descriptor word read request |
| mem_rd_addr | output | 32 | Byte address of the requested word |
| mem_rd_data | input | 32 | Read data, valid with the acknowledge |
| mem_rd_ack | input | 1 | Read acknowledge |
| sel_q | output | 16 | Visible selector |
| sel_rpl | output | 2 | Requested privilege level of the selector |
| seg_attr | output | 12 | Cached flag nibble and access byte |
| busy | output | 1 | Descriptor fetch in progress |
| xl_req | input | 1 | Translation request |
| xl_off | input | 32 | Offset to translate |
| xl_valid | output | 1 | Translation result valid |
| xl_lin | output | 32 | Linear address, 0 on fault |
| xl_fault | output | 1 | Limit or null fault |

## Verification
On every cycle the assertions check the following:
- the read request holds stable until it is acknowledged;
- a non-null write raises `busy`, and a null write never starts a read;
- writes made while busy leave the selector untouched;
- requests made while busy produce no result;
- a fault always reports a zero address.

The bench's sweeps over both tables, sixteen entries, several acknowledge delays and both granularities are what show the rest:
- the table address arithmetic;
- the reassembly of the split base and limit fields;
- the exact limit boundary, where the last offset passes and the next one faults;
- the pass-through state after reset.

// File: rtl/seg_shadow_pkg.sv
package seg_shadow_pkg;
  localparam int ADDR_W     = 32;
  localparam int SEL_W      = 16;
  localparam int RPL_W      = 2;
  localparam int IDX_W      = SEL_W - RPL_W - 1;
  localparam int LIM_W      = 20;
  localparam int PAGE_BITS  = ADDR_W - LIM_W;
  localparam int ATTR_W     = 12;
  localparam int DESC_SHIFT = 3;
  localparam int WORD_STEP  = 4;

  typedef struct packed {
    logic [ADDR_W-1:0] base;
    logic [ADDR_W-1:0] limit;
    logic [ATTR_W-1:0] attr;
    logic              nul;
  } seg_cache_t;

  typedef enum logic [1:0] {
    FS_IDLE = 2'd0,
    FS_LO   = 2'd1,
    FS_HI   = 2'd2
  } fetch_state_e;
endpackage

// File: rtl/seg_sel_decode.sv
module seg_sel_decode
  import seg_shadow_pkg::*;
(
  input  logic [SEL_W-1:RPL_W] sel_hi,
  input  logic [ADDR_W-1:0]    gdt_base,
  input  logic [ADDR_W-1:0]    ldt_base,
  output logic [ADDR_W-1:0]    desc_addr,
  output logic                 is_null
);
  logic [IDX_W-1:0]  idx;
  logic              tbl_sel;
  logic [ADDR_W-1:0] tbl_base;
  logic [ADDR_W-1:0] idx_ext;

  assign idx      = sel_hi[SEL_W-1:RPL_W+1];
  assign tbl_sel  = sel_hi[RPL_W];
  assign tbl_base = tbl_sel ? ldt_base : gdt_base;
  assign idx_ext  = {{(ADDR_W-IDX_W){1'b0}}, idx};
  assign desc_addr = tbl_base + (idx_ext << DESC_SHIFT);
  assign is_null  = (idx == '0) && !tbl_sel;
endmodule

// File: rtl/seg_desc_fetch.sv
module seg_desc_fetch
  import seg_shadow_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [ADDR_W-1:0] start_addr,
  output logic              mem_rd_req,
  output logic [ADDR_W-1:0] mem_rd_addr,
  input  logic [ADDR_W-1:0] mem_rd_data,
  input  logic              mem_rd_ack,
  output logic              busy,
  output logic              done,
  output logic [ADDR_W-1:0] lo_word
);
  fetch_state_e      state_q, state_d;
  logic [ADDR_W-1:0] addr_q, addr_d;
  logic [ADDR_W-1:0] lo_q, lo_d;
  logic              addr_en, lo_en;

  always_comb begin
    state_d = state_q;
    addr_d  = addr_q;
    lo_d    = lo_q;
    addr_en = 1'b0;
    lo_en   = 1'b0;
    done    = 1'b0;
    case (state_q)
      FS_IDLE: if (start) begin
        state_d = FS_LO;
        addr_d  = start_addr;
        addr_en = 1'b1;
      end
      FS_LO: if (mem_rd_ack) begin
        state_d = FS_HI;
        lo_d    = mem_rd_data;
        lo_en   = 1'b1;
        addr_d  = addr_q + ADDR_W'(WORD_STEP);
        addr_en = 1'b1;
      end
      FS_HI: if (mem_rd_ack) begin
        state_d = FS_IDLE;
        done    = 1'b1;
      end
      default: state_d = FS_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= FS_IDLE;
      addr_q  <= '0;
      lo_q    <= '0;
    end else begin
      state_q <= state_d;
      if (addr_en) addr_q <= addr_d;
      if (lo_en)   lo_q   <= lo_d;
    end
  end

  assign busy        = (state_q != FS_IDLE);
  assign mem_rd_req  = busy;
  assign mem_rd_addr = addr_q;
  assign lo_word     = lo_q;
endmodule

// File: rtl/seg_desc_unpack.sv
module seg_desc_unpack
  import seg_shadow_pkg::*;
(
  input  logic [ADDR_W-1:0] lo_word,
  input  logic [ADDR_W-1:0] hi_word,
  output seg_cache_t        cache
);
  logic [LIM_W-1:0] raw_lim;
  logic             gran;

  assign raw_lim = {hi_word[19:16], lo_word[15:0]};
  assign gran    = hi_word[23];

  always_comb begin
    cache.base  = {hi_word[31:24], hi_word[7:0], lo_word[31:16]};
    cache.limit = gran ? {raw_lim, {PAGE_BITS{1'b1}}}
                       : {{PAGE_BITS{1'b0}}, raw_lim};
    cache.attr  = {hi_word[23:20], hi_word[15:8]};
    cache.nul   = 1'b0;
  end
endmodule

// File: rtl/seg_xlate.sv
module seg_xlate
  import seg_shadow_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req,
  input  logic [ADDR_W-1:0] off,
  input  logic              stall,
  input  logic [ADDR_W-1:0] base,
  input  logic [ADDR_W-1:0] limit,
  input  logic              nul,
  output logic              valid,
  output logic [ADDR_W-1:0] lin,
  output logic              fault
);
  logic              accept;
  logic              fault_d, fault_q, valid_q;
  logic [ADDR_W-1:0] lin_d, lin_q;

  always_comb begin
    accept  = req && !stall;
    fault_d = nul || (off > limit);
    lin_d   = fault_d ? '0 : (base + off);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      fault_q <= 1'b0;
      lin_q   <= '0;
    end else begin
      valid_q <= accept;
      if (accept) begin
        fault_q <= fault_d;
        lin_q   <= lin_d;
      end
    end
  end

  assign valid = valid_q;
  assign lin   = lin_q;
  assign fault = fault_q;
endmodule

// File: rtl/seg_shadow_unit.sv
module seg_shadow_unit
  import seg_shadow_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sel_wr,
  input  logic [SEL_W-1:0]  sel_wdata,
  input  logic [ADDR_W-1:0] gdt_base,
  input  logic [ADDR_W-1:0] ldt_base,
  output logic              mem_rd_req,
  output logic [ADDR_W-1:0] mem_rd_addr,
  input  logic [ADDR_W-1:0] mem_rd_data,
  input  logic              mem_rd_ack,
  output logic [SEL_W-1:0]  sel_q,
  output logic [RPL_W-1:0]  sel_rpl,
  output logic [ATTR_W-1:0] seg_attr,
  output logic              busy,
  input  logic              xl_req,
  input  logic [ADDR_W-1:0] xl_off,
  output logic              xl_valid,
  output logic [ADDR_W-1:0] xl_lin,
  output logic              xl_fault
);
  logic [SEL_W-1:0]  sel_r, sel_d;
  seg_cache_t        cache_q, cache_d, cache_new;
  logic              cache_en, sel_load, wr_null, fetch_start, fetch_done;
  logic [ADDR_W-1:0] desc_addr, lo_word;

  seg_sel_decode u_dec (
    .sel_hi    (sel_wdata[SEL_W-1:RPL_W]),
    .gdt_base  (gdt_base),
    .ldt_base  (ldt_base),
    .desc_addr (desc_addr),
    .is_null   (wr_null)
  );

  seg_desc_fetch u_fetch (
    .clk         (clk),
    .rst_n       (rst_n),
    .start       (fetch_start),
    .start_addr  (desc_addr),
    .mem_rd_req  (mem_rd_req),
    .mem_rd_addr (mem_rd_addr),
    .mem_rd_data (mem_rd_data),
    .mem_rd_ack  (mem_rd_ack),
    .busy        (busy),
    .done        (fetch_done),
    .lo_word     (lo_word)
  );

  seg_desc_unpack u_unpack (
    .lo_word (lo_word),
    .hi_word (mem_rd_data),
    .cache   (cache_new)
  );

  always_comb begin
    sel_load    = sel_wr && !busy;
    fetch_start = sel_load && !wr_null;
    sel_d       = sel_load ? sel_wdata : sel_r;
    cache_d     = cache_q;
    cache_en    = 1'b0;
    if (sel_load && wr_null) begin
      cache_d.nul = 1'b1;
      cache_en    = 1'b1;
    end else if (fetch_done) begin
      cache_d  = cache_new;
      cache_en = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_r         <= '0;
      cache_q.base  <= '0;
      cache_q.limit <= '1;
      cache_q.attr  <= '0;
      cache_q.nul   <= 1'b0;
    end else begin
      sel_r <= sel_d;
      if (cache_en) cache_q <= cache_d;
    end
  end

  seg_xlate u_xl (
    .clk   (clk),
    .rst_n (rst_n),
    .req   (xl_req),
    .off   (xl_off),
    .stall (busy),
    .base  (cache_q.base),
    .limit (cache_q.limit),
    .nul   (cache_q.nul),
    .valid (xl_valid),
    .lin   (xl_lin),
    .fault (xl_fault)
  );

  assign sel_q    = sel_r;
  assign sel_rpl  = sel_r[RPL_W-1:0];
  assign seg_attr = cache_q.attr;
endmodule

// File: rtl/seg_shadow_chk.sv
module seg_shadow_chk
  import seg_shadow_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              sel_wr,
  input logic [SEL_W-1:0]  sel_wdata,
  input logic [SEL_W-1:0]  sel_q,
  input logic              busy,
  input logic              mem_rd_req,
  input logic              mem_rd_ack,
  input logic [ADDR_W-1:0] mem_rd_addr,
  input logic              xl_valid,
  input logic              xl_fault,
  input logic [ADDR_W-1:0] xl_lin
);
  logic wr_is_null;
  assign wr_is_null = (sel_wdata[SEL_W-1:RPL_W] == '0);

  // R3
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd_req && !mem_rd_ack |=> mem_rd_req && $stable(mem_rd_addr));

  // R3
  start_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sel_wr && !busy && !wr_is_null |=> busy);

  // R9
  null_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sel_wr && !busy && wr_is_null |=> !busy && !mem_rd_req);

  // R10
  busy_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sel_wr && busy |=> $stable(sel_q));

  // R7
  stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> !xl_valid);

  // R6
  fault_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    xl_valid && xl_fault |-> xl_lin == '0);
endmodule

bind seg_shadow_unit seg_shadow_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .sel_wr      (sel_wr),
  .sel_wdata   (sel_wdata),
  .sel_q       (sel_q),
  .busy        (busy),
  .mem_rd_req  (mem_rd_req),
  .mem_rd_ack  (mem_rd_ack),
  .mem_rd_addr (mem_rd_addr),
  .xl_valid    (xl_valid),
  .xl_fault    (xl_fault),
  .xl_lin      (xl_lin)
);

// File: tb/seg_shadow_unit_test.sv
module seg_shadow_unit_test;
  localparam logic [31:0] GDT = 32'h0000_1000;
  localparam logic [31:0] LDT = 32'h0008_4000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        sel_wr = 1'b0;
  logic [15:0] sel_wdata = '0;
  logic        mem_rd_req, mem_rd_ack = 1'b0;
  logic [31:0] mem_rd_addr, mem_rd_data = '0;
  logic [15:0] sel_q;
  logic [1:0]  sel_rpl;
  logic [11:0] seg_attr;
  logic        busy, xl_req = 1'b0, xl_valid, xl_fault;
  logic [31:0] xl_off = '0, xl_lin;

  int checks = 0, errors = 0;
  int cur_ti = 0, cur_idx = 0, wcnt = 0, rd_count = 0, dly = 0;

  always #10 clk = ~clk;

  seg_shadow_unit uut (
    .clk(clk), .rst_n(rst_n), .sel_wr(sel_wr), .sel_wdata(sel_wdata),
    .gdt_base(GDT), .ldt_base(LDT), .mem_rd_req(mem_rd_req),
    .mem_rd_addr(mem_rd_addr), .mem_rd_data(mem_rd_data),
    .mem_rd_ack(mem_rd_ack), .sel_q(sel_q), .sel_rpl(sel_rpl),
    .seg_attr(seg_attr), .busy(busy), .xl_req(xl_req), .xl_off(xl_off),
    .xl_valid(xl_valid), .xl_lin(xl_lin), .xl_fault(xl_fault)
  );

  task automatic chk(input bit ok, input string rq,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %h expected %h", rq, act, exp);
    end
  endtask

  function automatic logic [31:0] e_base(int ti, int idx);
    return 32'h0A00_0000 ^ (ti != 0 ? 32'h3000_0000 : 32'h0) ^ (idx * 32'h0101_0033);
  endfunction
  function automatic logic [19:0] e_l20(int idx);
    return 20'(idx * 32'h111 + 32'h40);
  endfunction
  function automatic logic e_g(int ti, int idx);
    return 1'((ti ^ idx) & 1);
  endfunction
  function automatic logic [31:0] e_limit(int ti, int idx);
    return e_g(ti, idx) ? {e_l20(idx), 12'hFFF} : {12'h0, e_l20(idx)};
  endfunction
  function automatic logic [11:0] e_attr(int ti, int idx);
    return {e_g(ti, idx), 3'b100, 8'(8'h80 + idx)};
  endfunction
  function automatic logic [31:0] e_word(int ti, int idx, int w);
    logic [31:0] b; logic [19:0] l; logic [11:0] a;
    b = e_base(ti, idx); l = e_l20(idx); a = e_attr(ti, idx);
    if (w == 0) return {b[15:0], l[15:0]};
    return {b[31:24], a[11:8], l[19:16], a[7:0], b[23:16]};
  endfunction

  // memory responder: acknowledge after dly idle cycles
  initial begin
    int cnt = 0;
    forever begin
      @(negedge clk);
      if (mem_rd_ack) mem_rd_ack = 1'b0;
      else if (mem_rd_req) begin
        if (cnt >= dly) begin
          // R2: table base plus eight times the entry, then +4
          chk(mem_rd_addr == ((cur_ti != 0 ? LDT : GDT) + 32'(cur_idx * 8 + wcnt * 4)),
              "R2", mem_rd_addr, (cur_ti != 0 ? LDT : GDT) + 32'(cur_idx * 8 + wcnt * 4));
          mem_rd_data = e_word(cur_ti, cur_idx, wcnt);
          mem_rd_ack  = 1'b1;
          wcnt++; rd_count++; cnt = 0;
        end else cnt++;
      end
    end
  end

  task automatic xlate(input logic [31:0] off, output logic v,
                       output logic [31:0] lin, output logic f);
    @(negedge clk); xl_req = 1'b1; xl_off = off;
    @(negedge clk); xl_req = 1'b0;
    v = xl_valid; lin = xl_lin; f = xl_fault;
  endtask

  task automatic wr_sel(input logic [15:0] s);
    @(negedge clk); sel_wr = 1'b1; sel_wdata = s;
    @(negedge clk); sel_wr = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual timeout expected completion");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic v, f; logic [31:0] lin;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R8 reset state
    chk(busy == 1'b0, "R8 busy", 32'(busy), 0);
    chk(sel_q == 16'h0, "R8 sel", 32'(sel_q), 0);
    xlate(32'h1234_5678, v, lin, f);
    chk(v && !f && lin == 32'h1234_5678, "R8 pass", lin, 32'h1234_5678);
    xlate(32'hFFFF_FFFF, v, lin, f);
    chk(v && !f && lin == 32'hFFFF_FFFF, "R8 max", lin, 32'hFFFF_FFFF);

    for (int ti = 0; ti < 2; ti++) begin
      for (int idx = 0; idx < 16; idx++) begin
        logic [15:0] s; int rc0; logic [31:0] b, lm;
        s = {13'(idx), 1'(ti), 2'(idx % 4)};
        cur_ti = ti; cur_idx = idx; wcnt = 0; dly = idx % 3; rc0 = rd_count;
        b = e_base(ti, idx); lm = e_limit(ti, idx);
        wr_sel(s);
        if (ti == 0 && idx == 0) begin
          // R9 null selector
          chk(busy == 1'b0, "R9 busy", 32'(busy), 0);
          xlate(32'h0, v, lin, f);
          chk(v && f && lin == 0, "R9 fault", 32'(f), 1);
          xlate(32'h10, v, lin, f);
          chk(v && f, "R9 fault2", 32'(f), 1);
          chk(rd_count == rc0, "R9 reads", 32'(rd_count), 32'(rc0));
          chk(sel_q == s, "R1 sel", 32'(sel_q), 32'(s));
        end else begin
          // R3 busy rises after write
          chk(busy == 1'b1, "R3 busy", 32'(busy), 1);
          if (idx == 5) begin
            xl_req = 1'b1; xl_off = 32'h4; sel_wr = 1'b1; sel_wdata = 16'hFFFF;
            @(negedge clk); sel_wr = 1'b0;
            chk(xl_valid == 1'b0, "R7 stall", 32'(xl_valid), 0);
            @(negedge clk);
            chk(xl_valid == 1'b0, "R7 stall2", 32'(xl_valid), 0);
            xl_req = 1'b0;
          end
          while (busy) @(negedge clk);
          chk(rd_count == rc0 + 2, "R3 two reads", 32'(rd_count), 32'(rc0 + 2));
          // R10 write during busy (idx 5) ignored; R1 fields
          chk(sel_q == s, "R1 R10 sel", 32'(sel_q), 32'(s));
          chk(sel_rpl == 2'(idx % 4), "R1 rpl", 32'(sel_rpl), 32'(idx % 4));
          chk(seg_attr == e_attr(ti, idx), "R4 attr", 32'(seg_attr), 32'(e_attr(ti, idx)));
          xlate(32'h0, v, lin, f);
          chk(v && !f && lin == b, "R4 base", lin, b);
          xlate(lm >> 1, v, lin, f);
          chk(v && !f && lin == b + (lm >> 1), "R5 mid", lin, b + (lm >> 1));
          xlate(lm, v, lin, f);
          chk(v && !f && lin == b + lm, "R5 limit", lin, b + lm);
          xlate(lm + 1, v, lin, f);
          chk(v && f && lin == 0, "R6 above", {31'h0, f}, 32'h1);
        end
      end
    end

    // R9 null again after valid cache, then R5 recovery
    cur_ti = 1; cur_idx = 2; wcnt = 0; dly = 0;
    wr_sel(16'h0003);
    xlate(32'h0, v, lin, f);
    chk(v && f, "R9 refault", 32'(f), 1);
    wr_sel({13'd2, 1'b1, 2'd0});
    while (busy) @(negedge clk);
    xlate(32'h8, v, lin, f);
    chk(v && !f && lin == e_base(1, 2) + 32'h8, "R5 reload", lin, e_base(1, 2) + 32'h8);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule